// File: doc/BRIEF.md
# BCD time-of-day and weekday counter

This block keeps the time of day (seconds, minutes, hours) and a day-of-week number as packed BCD counters. A prescaler divides the 32768 Hz reference clock into a one-cycle pulse once per second. That pulse advances the seconds, which carry into the minutes, then the hours, then the weekday. The block drives two packed words, one for time and one for the weekday, that a register file reads directly.

Software changes the stored values through a request/acknowledge handshake. Raising the time request stops the three time counters. Raising the calendar request stops only the weekday counter, so the time keeps running while the weekday is rewritten. The acknowledge comes on the next one-second pulse. After that the host may load new values, and dropping the request lets counting resume.

In 12-hour mode, a loaded hour and AM/PM flag are converted and stored as the equivalent 24-hour value. Reads therefore always return 24-hour time.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time word is 0x00000000, the calendar word is 0x00200000 (weekday 1) and `upd_ack` is 0.
- R2: `sec_tick` is high for exactly one clock in every 2^PRESCALE_BITS clocks (32768 at the default).
- R3: Seconds (time word bits 6:0) and minutes (bits 14:8) are BCD with units in the low nibble. They count 00 to 59, and a wrap carries into the next field.
- R4: Hours (time word bits 21:16) are BCD and count 00 to 23. The wrap from 23 to 00 carries into the weekday.
- R5: The weekday (calendar word bits 23:21) counts 1 to 7 in binary and wraps from 7 to 1.
- R6: While `upd_time_req` is high, seconds, minutes and hours do not advance.
- R7: While `upd_cal_req` is high, the weekday does not advance and the time keeps counting. A carry out of the hours during this period is lost.
- R8: `upd_ack` rises on the clock edge that ends a `sec_tick` cycle in which a request is high. It falls on the first edge after both requests are low.
- R9: A time load (`time_wr_en`) takes effect only when `upd_time_req` and `upd_ack` are both high. A weekday load (`cal_wr_en`) takes effect only when `upd_cal_req` and `upd_ack` are both high. Any other load is ignored. A load takes priority over a count in the same cycle.
- R10: With `hr12_mode` = 1, a loaded hour of 12 with `wr_pm` = 0 is stored as 00. A PM hour from 01 to 11 is stored with 12 added, and 12 with `wr_pm` = 1 stays 12. With `hr12_mode` = 0, the hour is stored as given and `wr_pm` is ignored.
- R11: All word bits outside the named fields read 0, including time word bit 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_time_req | input | 1 | Request to freeze and load the time counters |
| upd_cal_req | input | 1 | Request to freeze and load the weekday counter |
| hr12_mode | input | 1 | 1 selects 12-hour entry of loaded hours |
| time_wr_en | input | 1 | Load strobe for seconds, minutes and hours |
| wr_sec | input | 7 | BCD seconds to load |
| wr_min | input | 7 | BCD minutes to load |
| wr_hour | input | 6 | BCD hour to load |
| wr_pm | input | 1 | PM flag of a 12-hour load |
| cal_wr_en | input | 1 | Load strobe for the weekday |
| wr_day | input | 3 | Weekday to load, 1 to 7 |
| time_word | output | 32 | Packed current time |
| cal_word | output | 32 | Packed current weekday |
| upd_ack | output | 1 | Frozen counters may be loaded |
| sec_tick | output | 1 | One-second pulse |

## Verification
The assertions assume that the host loads only in-range BCD values, because this block does not validate entries. They also assume the host leaves at least one second between releasing a request and raising the next one. The stimulus loads only legal hours, minutes, seconds and weekdays. After every release it runs at least two full seconds before it raises a request again. Its ignored loads are made only in the no-request, no-acknowledge and wrong-request situations that R9 names.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int SEC_LSB  = 0;
   localparam int MIN_LSB  = 8;
   localparam int HOUR_LSB = 16;
   localparam int DAY_LSB  = 21;
   localparam int SEC_W    = 7;
   localparam int MIN_W    = 7;
   localparam int HOUR_W   = 6;
   localparam int DAY_W    = 3;

   function automatic logic [4:0] bcd6_to_bin(input logic [5:0] v);
      return 5'(v[5:4] * 4'd10 + {1'b0, v[3:0]});
   endfunction

   function automatic logic [5:0] bin_to_bcd6(input logic [4:0] b);
      logic [4:0] tens;
      logic [4:0] units;
      tens  = b / 5'd10;
      units = b - tens * 5'd10;
      return {tens[1:0], units[3:0]};
   endfunction

   // 12-hour entry to 24-hour storage value
   function automatic logic [5:0] hour12_to_24(input logic [5:0] h, input logic pm);
      logic [4:0] b;
      b = bcd6_to_bin(h);
      if (b == 5'd12) b = 5'd0;
      if (pm)         b = b + 5'd12;
      return bin_to_bcd6(b);
   endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int BITS = 15
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (BITS < 1 || BITS > 24) begin : g_bad_bits
         $error("rtc_prescaler: BITS out of range");
      end
   endgenerate

   logic [BITS-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign tick = &cnt_q;

   // R2: a pulse is never longer than one cycle
   assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/rtc_bcd_counter.sv
module rtc_bcd_counter #(
   parameter int W     = 7,
   parameter int FIRST = 0,
   parameter int LAST  = 'h59
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] val,
   output logic         carry
);
   localparam logic [W-1:0] FIRST_V = FIRST[W-1:0];
   localparam logic [W-1:0] LAST_V  = LAST[W-1:0];

   generate
      if (W < 2 || W > 8 || LAST <= FIRST) begin : g_bad_cfg
         $error("rtc_bcd_counter: bad configuration");
      end
   endgenerate

   logic [W-1:0] val_q;
   logic [W-1:0] inc;
   logic         at_last;

   generate
      if (W > 4) begin : g_bcd
         always_comb begin
            if (val_q[3:0] == 4'd9) inc = {val_q[W-1:4] + 1'b1, 4'd0};
            else                    inc = {val_q[W-1:4], val_q[3:0] + 4'd1};
         end
      end else begin : g_bin
         always_comb inc = val_q + 1'b1;
      end
   endgenerate

   assign at_last = (val_q == LAST_V);
   assign carry   = step & at_last;
   assign val     = val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val_q <= FIRST_V;
      else if (load) val_q <= load_val;
      else if (step) val_q <= at_last ? FIRST_V : inc;
   end

   // R3 (also R4, R5 through the hour and weekday instances): last value wraps to first
   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && at_last) |=> (val == FIRST_V));
   // R3: a step below the last value always changes the count
   assert_step_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !at_last) |=> (val != $past(val)));
   // R9: without step or load the count holds
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(val));
endmodule

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic time_req,
   input  logic cal_req,
   input  logic time_wr_en,
   input  logic cal_wr_en,
   output logic ack,
   output logic time_run,
   output logic cal_run,
   output logic time_load,
   output logic cal_load
);
   logic ack_q;
   logic any_req;

   assign any_req = time_req | cal_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ack_q <= 1'b0;
      else if (!any_req) ack_q <= 1'b0;
      else if (tick)    ack_q <= 1'b1;
   end

   assign ack       = ack_q;
   assign time_run  = tick & ~time_req;
   assign cal_run   = ~cal_req;
   assign time_load = time_wr_en & time_req & ack_q;
   assign cal_load  = cal_wr_en & cal_req & ack_q;

   // R8: acknowledge only rises after a one-second pulse
   assert_ack_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(tick));
   // R8: acknowledge drops once both requests are gone
   assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !any_req |=> !ack);
   // R9: no load is granted before acknowledge
   assert_load_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |-> !(time_load || cal_load));
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
   parameter int PRESCALE_BITS = 15
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        upd_time_req,
   input  logic        upd_cal_req,
   input  logic        hr12_mode,
   input  logic        time_wr_en,
   input  logic [6:0]  wr_sec,
   input  logic [6:0]  wr_min,
   input  logic [5:0]  wr_hour,
   input  logic        wr_pm,
   input  logic        cal_wr_en,
   input  logic [2:0]  wr_day,
   output logic [31:0] time_word,
   output logic [31:0] cal_word,
   output logic        upd_ack,
   output logic        sec_tick
);
   import rtc_pkg::*;

   localparam int TICK_PERIOD = 1 << PRESCALE_BITS;

   generate
      if (TICK_PERIOD < 2) begin : g_bad_period
         $error("bcd_rtc_core: prescaler period too short");
      end
   endgenerate

   logic              time_run, cal_run, time_load, cal_load;
   logic              sec_carry, min_carry, hour_carry;
   logic [SEC_W-1:0]  sec_v;
   logic [MIN_W-1:0]  min_v;
   logic [HOUR_W-1:0] hour_v, hour_in;
   logic [DAY_W-1:0]  day_v;

   rtc_prescaler #(.BITS(PRESCALE_BITS)) i_prescaler (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick));

   rtc_update_ctrl i_update_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick),
      .time_req(upd_time_req), .cal_req(upd_cal_req),
      .time_wr_en(time_wr_en), .cal_wr_en(cal_wr_en),
      .ack(upd_ack), .time_run(time_run), .cal_run(cal_run),
      .time_load(time_load), .cal_load(cal_load));

   assign hour_in = hr12_mode ? hour12_to_24(wr_hour, wr_pm) : wr_hour;

   rtc_bcd_counter #(.W(SEC_W), .FIRST(0), .LAST('h59)) i_sec (
      .clk(clk), .rst_n(rst_n), .step(time_run), .load(time_load),
      .load_val(wr_sec), .val(sec_v), .carry(sec_carry));

   rtc_bcd_counter #(.W(MIN_W), .FIRST(0), .LAST('h59)) i_min (
      .clk(clk), .rst_n(rst_n), .step(sec_carry), .load(time_load),
      .load_val(wr_min), .val(min_v), .carry(min_carry));

   rtc_bcd_counter #(.W(HOUR_W), .FIRST(0), .LAST('h23)) i_hour (
      .clk(clk), .rst_n(rst_n), .step(min_carry), .load(time_load),
      .load_val(hour_in), .val(hour_v), .carry(hour_carry));

   logic day_step;
   logic day_carry_unused;
   assign day_step = hour_carry & cal_run;

   rtc_bcd_counter #(.W(DAY_W), .FIRST(1), .LAST(7)) i_day (
      .clk(clk), .rst_n(rst_n), .step(day_step), .load(cal_load),
      .load_val(wr_day), .val(day_v), .carry(day_carry_unused));

   always_comb begin
      time_word = '0;
      time_word[SEC_LSB  +: SEC_W]  = sec_v;
      time_word[MIN_LSB  +: MIN_W]  = min_v;
      time_word[HOUR_LSB +: HOUR_W] = hour_v;
      cal_word = '0;
      cal_word[DAY_LSB +: DAY_W] = day_v;
   end

   // R6: time fields hold while the time request is up and nothing is loaded
   assert_time_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_time_req && !time_load) |=> $stable(time_word));
   // R7: weekday holds while the calendar request is up and nothing is loaded
   assert_day_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_cal_req && !cal_load) |=> $stable(cal_word));
   // R10: 12 AM loaded in 12-hour mode reads back as hour 00
   assert_midnight_conv_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (time_load && hr12_mode && wr_hour == 6'h12 && !wr_pm) |=> (time_word[21:16] == 6'h00));
   // R11: unused bits stay zero
   assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (time_word[31:22] == '0) && (cal_word[20:0] == '0) && (cal_word[31:24] == '0));
endmodule

// File: tb/test_bcd_rtc_core.sv
module test_bcd_rtc_core;
   localparam int CLK_PERIOD = 10;
   localparam int PB         = 2;
   localparam int PERIOD     = 1 << PB;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_time_req = 1'b0, upd_cal_req = 1'b0, hr12_mode = 1'b0;
   logic        time_wr_en = 1'b0, cal_wr_en = 1'b0, wr_pm = 1'b0;
   logic [6:0]  wr_sec = '0, wr_min = '0;
   logic [5:0]  wr_hour = '0;
   logic [2:0]  wr_day = '0;
   logic [31:0] time_word, cal_word;
   logic        upd_ack, sec_tick;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 0;

   int exp_secs = 0;
   int exp_day  = 1;
   bit exp_ack  = 0;
   int ld_secs  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_rtc_core #(.PRESCALE_BITS(PB)) i_bcd_rtc_core (
      .clk(clk), .rst_n(rst_n), .upd_time_req(upd_time_req), .upd_cal_req(upd_cal_req),
      .hr12_mode(hr12_mode), .time_wr_en(time_wr_en), .wr_sec(wr_sec), .wr_min(wr_min),
      .wr_hour(wr_hour), .wr_pm(wr_pm), .cal_wr_en(cal_wr_en), .wr_day(wr_day),
      .time_word(time_word), .cal_word(cal_word), .upd_ack(upd_ack), .sec_tick(sec_tick));

   function automatic logic [7:0] bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic logic [31:0] time_exp(input int s);
      return (32'(bcd(s / 3600)) << 16) | (32'(bcd((s / 60) % 60)) << 8) | 32'(bcd(s % 60));
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // One clock: update the model from the inputs driven this cycle, then compare.
   task automatic cyc(input string tag);
      bit tk, acc_t, acc_c;
      tk    = sec_tick;
      acc_t = time_wr_en && upd_time_req && exp_ack;
      acc_c = cal_wr_en && upd_cal_req && exp_ack;
      @(negedge clk);
      if (acc_t) exp_secs = ld_secs;
      else if (tk && !upd_time_req) begin
         exp_secs++;
         if (exp_secs == 86400) begin
            exp_secs = 0;
            if (!upd_cal_req) exp_day = (exp_day == 7) ? 1 : exp_day + 1;
         end
      end
      if (acc_c) exp_day = int'(wr_day);
      if (!(upd_time_req || upd_cal_req)) exp_ack = 0;
      else if (tk) exp_ack = 1;
      chk(time_word == time_exp(exp_secs), {tag, " R3 R4 R6 R11 time"}, time_word, time_exp(exp_secs));
      chk(cal_word == (32'(exp_day) << 21), {tag, " R5 R7 R11 day"}, cal_word, 32'(exp_day) << 21);
      chk(upd_ack == exp_ack, {tag, " R8 ack"}, 32'(upd_ack), 32'(exp_ack));
   endtask

   task automatic run_secs(input int n, input string tag);
      for (int i = 0; i < n * PERIOD; i++) cyc(tag);
   endtask

   task automatic wait_ack(input string tag);
      for (int i = 0; i < PERIOD + 2 && !exp_ack; i++) cyc(tag);
      chk(upd_ack == 1'b1, {tag, " R8 ack seen"}, 32'(upd_ack), 32'd1);
   endtask

   task automatic release_all(input string tag);
      upd_time_req = 0; upd_cal_req = 0;
      cyc(tag);
      run_secs(2, tag);
   endtask

   task automatic load_time(input int h, input int m, input int s, input bit pm, input bit m12,
                            input int exp_h, input string tag);
      wr_hour = 6'(bcd(h)); wr_min = 7'(bcd(m)); wr_sec = 7'(bcd(s));
      wr_pm = pm; hr12_mode = m12; ld_secs = exp_h * 3600 + m * 60 + s;
      time_wr_en = 1;
      cyc(tag);
      time_wr_en = 0;
   endtask

   task automatic load_day(input int d, input string tag);
      wr_day = 3'(d); cal_wr_en = 1;
      cyc(tag);
      cal_wr_en = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(time_word == 32'h0, "R1 time reset", time_word, 32'h0);
      chk(cal_word == 32'h0020_0000, "R1 day reset", cal_word, 32'h0020_0000);
      chk(upd_ack == 1'b0, "R1 ack reset", 32'(upd_ack), 32'd0);
      rst_n = 1;

      // R2: pulse spacing
      while (!sec_tick) cyc("R2 align");
      for (int k = 0; k < 3; k++) begin
         int n;
         n = 0;
         do begin cyc("R2"); n++; end while (!sec_tick);
         chk(n == PERIOD, "R2 tick period", 32'(n), 32'(PERIOD));
      end

      // R3/R4: run just over one hour, every second compared
      run_secs(3700, "R3 sweep");

      // R9: loads with no request are ignored
      load_time(5, 5, 5, 0, 0, 5, "R9 no req");
      load_day(4, "R9 no req");

      // R9: load before acknowledge is ignored; then R4 hour sweep
      while (!sec_tick) cyc("R9 align");
      cyc("R9 align");
      upd_time_req = 1;
      load_time(7, 7, 7, 0, 0, 7, "R9 before ack");
      wait_ack("R6");
      run_secs(2, "R6 frozen");
      load_day(3, "R9 wrong req");
      release_all("R8 release");

      for (int h = 0; h < 24; h++) begin
         upd_time_req = 1;
         wait_ack("R4 sweep");
         load_time(h, 59, 59, 0, 0, h, "R4 sweep");
         release_all("R4 rollover");
      end

      // R5: weekday wrap sweep
      for (int d = 1; d <= 7; d++) begin
         upd_time_req = 1; upd_cal_req = 1;
         wait_ack("R5 sweep");
         load_day(d, "R5 load");
         load_time(23, 59, 58, 0, 0, 23, "R5 load");
         release_all("R5 wrap");
      end

      // R7: calendar-only freeze keeps time running and drops the day carry
      upd_time_req = 1;
      wait_ack("R7 setup");
      load_time(23, 59, 50, 0, 0, 23, "R7 setup");
      release_all("R7 setup");
      upd_cal_req = 1;
      wait_ack("R7 freeze");
      load_time(1, 2, 3, 0, 0, 1, "R9 time under cal req");
      run_secs(10, "R7 carry lost");
      load_day(6, "R7 load");
      release_all("R7 release");

      // R10: 12-hour entry conversion, both halves of the day
      upd_time_req = 1;
      wait_ack("R10");
      for (int h = 1; h <= 12; h++) begin
         for (int p = 0; p < 2; p++) begin
            int e;
            e = (h == 12) ? (p != 0 ? 12 : 0) : (p != 0 ? h + 12 : h);
            load_time(h, 30, 15, p[0], 1, e, "R10 12h");
         end
      end
      load_time(9, 0, 0, 1, 0, 9, "R10 24h pm ignored");
      hr12_mode = 0;
      release_all("R10 release");

      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      done = 1;
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         n_errs++;
         n_checks++;
         $display("FAIL watchdog act=running exp=finished");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end
endmodule